// File: doc/BRIEF.md
# High-speed burst lane sequencer

This block is the transmit-side lane-state controller for a serial display link that has one clock lane and a parameterised number of data lanes. When a burst is requested, it takes the clock lane out of low-power idle and starts the high-speed clock. After the clock has run for a set time, it takes the data lanes through their own low-power entry, the zero preamble and a sync marker. It then streams one byte per lane per core cycle and closes the burst. The data lanes trail out first, the clock keeps running for a post interval and then trails, and both lanes sit in the stop state for a minimum exit time.

The outputs are abstract line states: a two-bit low-power level per lane, a high-speed enable, a clock-running flag on the clock lane, and a per-lane select. The select tells the serialiser below whether to send zeros, the sync marker, payload or the inverted trail state. Every interval is a parameter counted in core-clock cycles, already rounded up from the nanosecond and unit-interval minima of the link. A request that arrives while a burst is in flight is held, with its length, until the exit interval has been served.

Top module: `link_burst_seq`

## Requirements
- R1: After reset and while idle, both lanes show the stop state: low-power code 2'b11 (bit 1 is the positive line, bit 0 the negative line), high-speed enable 0, clock-running 0, select 0, payload bytes 0 and `data_rd_o` 0.
- R2: An accepted burst drives the clock lane with code 2'b01 for `T_LPX` cycles, then 2'b00 for `CLK_PREP` cycles, then high-speed zero (enable 1, running 0) for `CLK_ZERO` cycles.
- R3: The clock then runs (enable 1, running 1) for `CLK_PRE` cycles while the data lanes stay in stop. A data lane is never out of stop unless the clock lane is running.
- R4: The data lanes then drive code 2'b01 for `T_LPX` cycles, then 2'b00 for `HS_PREP` cycles, then high-speed zero (select 0) for `HS_ZERO` cycles, then the sync marker (select 1) for exactly one cycle.
- R5: The payload lasts `len_i`+1 cycles with select 2. In those cycles the byte of lane l equals `data_i[8l+7:8l]` and `data_rd_o` is 1. In every other cycle `data_rd_o` is 0 and the bytes are 0.
- R6: After the payload, the data lanes drive the trail state (select 3) for `HS_TRAIL` cycles and then return to stop.
- R7: Once the data lanes are back in stop, the clock keeps running for `CLK_POST` cycles. The clock lane then drives high-speed zero for `CLK_TRAIL` cycles and then stop for at least `HS_EXIT` cycles.
- R8: A request made during a burst is held together with the `len_i` it carried. It starts its burst (clock code 2'b01) in the cycle that follows the `HS_EXIT`-th stop cycle. A fresh request in the last exit cycle behaves the same way.
- R9: A request sampled at a clock edge while idle puts the clock lane in code 2'b01 in the cycle after that edge.
- R10: All data lanes show the same low-power code, high-speed enable and select in every cycle.
- R11: No lane state ends before its parameter count has elapsed. Each timed state lasts exactly its parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Burst request, sampled each edge |
| len_i | input | LEN_W | Payload length minus one, in words, taken with the request |
| data_i | input | LANES*BYTE_W | Current payload word, one byte per lane |
| data_rd_o | output | 1 | Current word is consumed this cycle |
| clk_lp_o | output | 2 | Clock lane low-power code {P,N} |
| clk_hs_en_o | output | 1 | Clock lane in high-speed mode |
| clk_run_o | output | 1 | High-speed clock toggling (else HS-0) |
| dat_lp_o | output | 2*LANES | Per data lane low-power code {P,N} |
| dat_hs_en_o | output | LANES | Per data lane high-speed enable |
| dat_sel_o | output | 2*LANES | Per lane select: 0 zero, 1 sync, 2 payload, 3 trail |
| dat_byte_o | output | LANES*BYTE_W | Per lane payload byte |

## Verification
Two events can fall in the same cycle. One is the end of the exit interval, which would otherwise send the clock lane back to idle. The other is a request, either one already pending or a fresh one. The bench raises a request during the payload of one burst, and another exactly in the last stop cycle of a burst. In both cases it requires the clock lane to show code 2'b01 in the very next cycle, with no idle cycle in between, and the held length to set the size of the second payload. Every interval of both bursts is measured cycle by cycle against the parameters.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [3:0] {
    C_IDLE, C_LP01, C_LP00, C_ZERO, C_PRE, C_RUN, C_POST, C_TRAIL, C_EXIT
  } clk_st_e;

  typedef enum logic [2:0] {
    D_IDLE, D_LP01, D_LP00, D_ZERO, D_SYNC, D_DATA, D_TRAIL
  } dat_st_e;

  localparam logic [1:0] LP_STOP   = 2'b11;
  localparam logic [1:0] LP_REQ    = 2'b01;
  localparam logic [1:0] LP_BRIDGE = 2'b00;

  localparam logic [1:0] SEL_ZERO  = 2'd0;
  localparam logic [1:0] SEL_SYNC  = 2'd1;
  localparam logic [1:0] SEL_DATA  = 2'd2;
  localparam logic [1:0] SEL_TRAIL = 2'd3;
endpackage

// File: rtl/lbs_clk_fsm.sv
module lbs_clk_fsm
  import lbs_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int T_LPX     = 2,
  parameter int CLK_PREP  = 2,
  parameter int CLK_ZERO  = 6,
  parameter int CLK_PRE   = 2,
  parameter int CLK_POST  = 5,
  parameter int CLK_TRAIL = 2,
  parameter int HS_EXIT   = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       dat_done_i,
  output logic       ready_o,
  output logic       dat_go_o,
  output clk_st_e    st_o,
  output logic [1:0] lp_o,
  output logic       hs_en_o,
  output logic       run_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  clk_st_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] dwell_q;
  logic expired;

  function automatic logic [CNT_W-1:0] load_of(input clk_st_e s);
    case (s)
      C_LP01:  return CNT_W'(T_LPX - 1);
      C_LP00:  return CNT_W'(CLK_PREP - 1);
      C_ZERO:  return CNT_W'(CLK_ZERO - 1);
      C_PRE:   return CNT_W'(CLK_PRE - 1);
      C_POST:  return CNT_W'(CLK_POST - 1);
      C_TRAIL: return CNT_W'(CLK_TRAIL - 1);
      C_EXIT:  return CNT_W'(HS_EXIT - 1);
      default: return '0;
    endcase
  endfunction

  assign expired = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = expired ? cnt_q : cnt_q - 1'b1;
    unique case (st_q)
      C_IDLE:  if (start_i) st_d = C_LP01;
      C_LP01:  if (expired) st_d = C_LP00;
      C_LP00:  if (expired) st_d = C_ZERO;
      C_ZERO:  if (expired) st_d = C_PRE;
      C_PRE:   if (expired) st_d = C_RUN;
      C_RUN:   if (dat_done_i) st_d = C_POST;
      C_POST:  if (expired) st_d = C_TRAIL;
      C_TRAIL: if (expired) st_d = C_EXIT;
      C_EXIT:  if (expired) st_d = start_i ? C_LP01 : C_IDLE;
      default: st_d = C_IDLE;
    endcase
    if (st_d != st_q) cnt_d = load_of(st_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= C_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  // cycles spent in the current state, for the interval self-check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              dwell_q <= '0;
    else if (st_d != st_q)    dwell_q <= '0;
    else if (dwell_q != CNT_MAX) dwell_q <= dwell_q + 1'b1;
  end

  assign ready_o  = (st_q == C_IDLE) || ((st_q == C_EXIT) && expired);
  assign dat_go_o = (st_q == C_PRE) && expired;
  assign st_o     = st_q;

  always_comb begin
    unique case (st_q)
      C_IDLE, C_EXIT: lp_o = LP_STOP;
      C_LP01:         lp_o = LP_REQ;
      default:        lp_o = LP_BRIDGE;
    endcase
  end
  assign hs_en_o = st_q inside {C_ZERO, C_PRE, C_RUN, C_POST, C_TRAIL};
  assign run_o   = st_q inside {C_PRE, C_RUN, C_POST};

  AST_CLK_MIN_DWELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_d != st_q) && !(st_q inside {C_IDLE, C_RUN})) |-> (dwell_q >= load_of(st_q))); // R11
  AST_CLK_PREP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == C_LP01) |=> (st_q inside {C_LP01, C_LP00})); // R2
endmodule

// File: rtl/lbs_dat_fsm.sv
module lbs_dat_fsm
  import lbs_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int LEN_W    = 8,
  parameter int T_LPX    = 2,
  parameter int HS_PREP  = 2,
  parameter int HS_ZERO  = 4,
  parameter int HS_TRAIL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o,
  output dat_st_e          st_o,
  output logic [1:0]       lp_o,
  output logic             hs_en_o,
  output logic [1:0]       sel_o
);
  localparam int DW = (CNT_W > LEN_W) ? CNT_W : LEN_W;
  localparam logic [DW-1:0] DW_MAX = '1;

  dat_st_e st_q, st_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] dwell_q;
  logic expired;

  function automatic logic [DW-1:0] load_of(input dat_st_e s, input logic [LEN_W-1:0] n);
    case (s)
      D_LP01:  return DW'(T_LPX - 1);
      D_LP00:  return DW'(HS_PREP - 1);
      D_ZERO:  return DW'(HS_ZERO - 1);
      D_DATA:  return DW'(n);
      D_TRAIL: return DW'(HS_TRAIL - 1);
      default: return '0;
    endcase
  endfunction

  assign expired = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = expired ? cnt_q : cnt_q - 1'b1;
    unique case (st_q)
      D_IDLE:  if (go_i) st_d = D_LP01;
      D_LP01:  if (expired) st_d = D_LP00;
      D_LP00:  if (expired) st_d = D_ZERO;
      D_ZERO:  if (expired) st_d = D_SYNC;
      D_SYNC:  st_d = D_DATA;
      D_DATA:  if (expired) st_d = D_TRAIL;
      D_TRAIL: if (expired) st_d = D_IDLE;
      default: st_d = D_IDLE;
    endcase
    if (st_d != st_q) cnt_d = load_of(st_d, len_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= D_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              dwell_q <= '0;
    else if (st_d != st_q)    dwell_q <= '0;
    else if (dwell_q != DW_MAX) dwell_q <= dwell_q + 1'b1;
  end

  assign done_o = (st_q == D_TRAIL) && expired;
  assign st_o   = st_q;

  always_comb begin
    unique case (st_q)
      D_IDLE:  lp_o = LP_STOP;
      D_LP01:  lp_o = LP_REQ;
      default: lp_o = LP_BRIDGE;
    endcase
    unique case (st_q)
      D_SYNC:  sel_o = SEL_SYNC;
      D_DATA:  sel_o = SEL_DATA;
      D_TRAIL: sel_o = SEL_TRAIL;
      default: sel_o = SEL_ZERO;
    endcase
  end
  assign hs_en_o = st_q inside {D_ZERO, D_SYNC, D_DATA, D_TRAIL};

  AST_DAT_MIN_DWELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_d != st_q) && (st_q != D_IDLE)) |-> (dwell_q >= load_of(st_q, len_i))); // R11
  AST_SYNC_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == D_SYNC) |=> (st_q == D_DATA)); // R4
endmodule

// File: rtl/link_burst_seq.sv
module link_burst_seq
  import lbs_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int BYTE_W    = 8,
  parameter int LEN_W     = 8,
  parameter int CNT_W     = 8,
  parameter int T_LPX     = 2,
  parameter int CLK_PREP  = 2,
  parameter int CLK_ZERO  = 6,
  parameter int CLK_PRE   = 2,
  parameter int HS_PREP   = 2,
  parameter int HS_ZERO   = 4,
  parameter int HS_TRAIL  = 2,
  parameter int CLK_POST  = 5,
  parameter int CLK_TRAIL = 2,
  parameter int HS_EXIT   = 6
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [LANES*BYTE_W-1:0] data_i,
  output logic                    data_rd_o,
  output logic [1:0]              clk_lp_o,
  output logic                    clk_hs_en_o,
  output logic                    clk_run_o,
  output logic [2*LANES-1:0]      dat_lp_o,
  output logic [LANES-1:0]        dat_hs_en_o,
  output logic [2*LANES-1:0]      dat_sel_o,
  output logic [LANES*BYTE_W-1:0] dat_byte_o
);
  localparam int BUS_W = LANES * BYTE_W;

  clk_st_e clk_st;
  dat_st_e dat_st;
  logic ready, accept, dat_go, dat_done;
  logic pend_q;
  logic [LEN_W-1:0] pend_len_q, cur_len_q;
  logic [1:0] dat_lp, dat_sel;
  logic dat_hs;

  // one request may wait for the exit interval; later ones are dropped
  assign accept = ready && (req_i || pend_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_len_q <= '0;
      cur_len_q  <= '0;
    end else if (accept) begin
      pend_q    <= 1'b0;
      cur_len_q <= pend_q ? pend_len_q : len_i;
    end else if (req_i && !pend_q) begin
      pend_q     <= 1'b1;
      pend_len_q <= len_i;
    end
  end

  lbs_clk_fsm #(
    .CNT_W(CNT_W), .T_LPX(T_LPX), .CLK_PREP(CLK_PREP), .CLK_ZERO(CLK_ZERO),
    .CLK_PRE(CLK_PRE), .CLK_POST(CLK_POST), .CLK_TRAIL(CLK_TRAIL), .HS_EXIT(HS_EXIT)
  ) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(accept), .dat_done_i(dat_done),
    .ready_o(ready), .dat_go_o(dat_go), .st_o(clk_st),
    .lp_o(clk_lp_o), .hs_en_o(clk_hs_en_o), .run_o(clk_run_o)
  );

  lbs_dat_fsm #(
    .CNT_W(CNT_W), .LEN_W(LEN_W), .T_LPX(T_LPX), .HS_PREP(HS_PREP),
    .HS_ZERO(HS_ZERO), .HS_TRAIL(HS_TRAIL)
  ) u_dat (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(dat_go), .len_i(cur_len_q),
    .done_o(dat_done), .st_o(dat_st), .lp_o(dat_lp), .hs_en_o(dat_hs), .sel_o(dat_sel)
  );

  assign data_rd_o = (dat_st == D_DATA);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign dat_lp_o[2*l +: 2]          = dat_lp;
    assign dat_hs_en_o[l]              = dat_hs;
    assign dat_sel_o[2*l +: 2]         = dat_sel;
    assign dat_byte_o[BYTE_W*l +: BYTE_W] = data_rd_o ? data_i[BYTE_W*l +: BYTE_W] : '0;
  end

  AST_DATA_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_st != D_IDLE) |-> (clk_st == C_RUN)); // R3
  AST_CLK_TAIL_DATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_st inside {C_POST, C_TRAIL, C_EXIT}) |-> (dat_st == D_IDLE)); // R7
  AST_RD_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rd_o |-> (dat_hs_en_o[0] && clk_run_o)); // R5
  AST_PEND_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !ready) |=> pend_q); // R8
  AST_BYTES_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_rd_o |-> (dat_byte_o == BUS_W'(0))); // R5
endmodule

// File: tb/link_burst_seq_tb.sv
module link_burst_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4, BYTE_W = 8, LEN_W = 8, CNT_W = 8;
  localparam int T_LPX = 2, CLK_PREP = 2, CLK_ZERO = 6, CLK_PRE = 2;
  localparam int HS_PREP = 2, HS_ZERO = 4, HS_TRAIL = 2;
  localparam int CLK_POST = 5, CLK_TRAIL = 2, HS_EXIT = 6;
  localparam int BUS_W = LANES * BYTE_W;

  // phase codes used by the bench
  localparam int CP_STOP = 0, CP_REQ = 1, CP_BR = 2, CP_ZERO = 3, CP_RUN = 4;
  localparam int DP_STOP = 0, DP_REQ = 1, DP_BR = 2, DP_ZERO = 3, DP_SYNC = 4, DP_DATA = 5, DP_TRAIL = 6;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [BUS_W-1:0] data;
  logic rd, clk_hs, clk_run;
  logic [1:0] clk_lp;
  logic [2*LANES-1:0] dat_lp, dat_sel;
  logic [LANES-1:0] dat_hs;
  logic [BUS_W-1:0] dat_byte;

  int checks = 0, failures = 0;
  int idx = 0, exp_word = 0;
  bit lanes_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_burst_seq #(
    .LANES(LANES), .BYTE_W(BYTE_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .T_LPX(T_LPX), .CLK_PREP(CLK_PREP), .CLK_ZERO(CLK_ZERO), .CLK_PRE(CLK_PRE),
    .HS_PREP(HS_PREP), .HS_ZERO(HS_ZERO), .HS_TRAIL(HS_TRAIL),
    .CLK_POST(CLK_POST), .CLK_TRAIL(CLK_TRAIL), .HS_EXIT(HS_EXIT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .len_i(len), .data_i(data),
    .data_rd_o(rd), .clk_lp_o(clk_lp), .clk_hs_en_o(clk_hs), .clk_run_o(clk_run),
    .dat_lp_o(dat_lp), .dat_hs_en_o(dat_hs), .dat_sel_o(dat_sel), .dat_byte_o(dat_byte)
  );

  function automatic logic [BUS_W-1:0] pat(input int w);
    logic [BUS_W-1:0] r;
    for (int l = 0; l < LANES; l++) r[BYTE_W*l +: BYTE_W] = BYTE_W'(w * 7 + l * 16 + 3);
    return r;
  endfunction

  assign data = pat(idx);
  always @(posedge clk) if (rd) idx <= idx + 1;

  function automatic logic [1:0] lp_of(input int ph);
    if (ph == 0) return 2'b11;
    if (ph == 1) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [1:0] sel_of(input int ph);
    if (ph == DP_SYNC)  return 2'd1;
    if (ph == DP_DATA)  return 2'd2;
    if (ph == DP_TRAIL) return 2'd3;
    return 2'd0;
  endfunction

  function automatic bit lanes_same();
    for (int l = 1; l < LANES; l++)
      if (dat_lp[2*l +: 2] != dat_lp[1:0] || dat_hs[l] != dat_hs[0] ||
          dat_sel[2*l +: 2] != dat_sel[1:0]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string rq, input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // n cycles of one phase pair, sampled at negedges, one check per segment
  task automatic seg(input string rq, input int n, input int cph, input int dph);
    bit ok = 1'b1;
    logic [63:0] a = '0, e = '0;
    for (int i = 0; i < n; i++) begin
      logic [8:0] ev, ov;
      logic [BUS_W-1:0] eb;
      logic erd;
      ev  = {lp_of(cph), cph >= CP_ZERO, cph == CP_RUN, lp_of(dph), dph >= DP_ZERO, sel_of(dph)};
      ov  = {clk_lp, clk_hs, clk_run, dat_lp[1:0], dat_hs[0], dat_sel[1:0]};
      erd = (dph == DP_DATA);
      eb  = erd ? pat(exp_word) : '0;
      if (!lanes_same()) lanes_bad = 1'b1;
      if (ok && (ov != ev || rd != erd || dat_byte != eb)) begin
        ok = 1'b0;
        a  = 64'({rd, ov, dat_byte});
        e  = 64'({erd, ev, eb});
      end
      if (erd) exp_word++;
      @(negedge clk);
    end
    check(rq, ok, $sformatf("segment len=%0d clk_ph=%0d dat_ph=%0d", n, cph, dph), a, e);
  endtask

  task automatic pulse_req(input int l);
    req = 1'b1;
    len = LEN_W'(l);
    fork
      begin @(negedge clk); req = 1'b0; end
    join_none
  endtask

  task automatic burst_front(input string first_rq);
    seg(first_rq, T_LPX, CP_REQ, DP_STOP);
    seg("R2", CLK_PREP, CP_BR, DP_STOP);
    seg("R2", CLK_ZERO, CP_ZERO, DP_STOP);
    seg("R3", CLK_PRE, CP_RUN, DP_STOP);
    seg("R4", T_LPX, CP_RUN, DP_REQ);
    seg("R4", HS_PREP, CP_RUN, DP_BR);
    seg("R4", HS_ZERO, CP_RUN, DP_ZERO);
    seg("R4", 1, CP_RUN, DP_SYNC);
  endtask

  task automatic burst_back(input int words);
    seg("R5", words, CP_RUN, DP_DATA);
    seg("R6", HS_TRAIL, CP_RUN, DP_TRAIL);
    seg("R7", CLK_POST, CP_RUN, DP_STOP);
    seg("R7", CLK_TRAIL, CP_ZERO, DP_STOP);
  endtask

  task automatic t_reset();
    seg("R1", 4, CP_STOP, DP_STOP);
  endtask

  task automatic t_single(input int l);
    pulse_req(l);
    @(negedge clk);
    burst_front("R9");
    burst_back(l + 1);
    seg("R11", HS_EXIT, CP_STOP, DP_STOP);
    seg("R1", 3, CP_STOP, DP_STOP);
  endtask

  task automatic t_held(input int la, input int lb);
    pulse_req(la);
    @(negedge clk);
    burst_front("R2");
    pulse_req(lb);  // lands in the first payload cycle
    burst_back(la + 1);
    seg("R8", HS_EXIT, CP_STOP, DP_STOP);
    burst_front("R8");
    burst_back(lb + 1);
    seg("R7", HS_EXIT, CP_STOP, DP_STOP);
    seg("R1", 2, CP_STOP, DP_STOP);
  endtask

  task automatic t_exit_edge(input int la, input int lb);
    pulse_req(la);
    @(negedge clk);
    burst_front("R2");
    burst_back(la + 1);
    seg("R7", HS_EXIT - 1, CP_STOP, DP_STOP);
    pulse_req(lb);  // last exit cycle
    seg("R8", 1, CP_STOP, DP_STOP);
    burst_front("R8");
    burst_back(lb + 1);
    seg("R7", HS_EXIT, CP_STOP, DP_STOP);
    seg("R1", 2, CP_STOP, DP_STOP);
  endtask

  initial begin
    bit timed_out = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_single(3);
        t_single(0);
        t_held(5, 2);
        t_exit_edge(1, 4);
        check("R10", !lanes_bad, "lanes differ", 64'(lanes_bad), 64'(0));
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check("R1", 1'b0, "watchdog expired", 64'(1), 64'(0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule